// File: doc/BRIEF.md
# Memory performance counter unit

The unit counts activity inside a memory subsystem. Up to 64 single-cycle event strobes arrive on `ev_pulse`. Sixteen 32-bit general counters can each be pointed at one of these strobes and enabled on its own. A 56-bit counter advances on every clock while counting is running. Software uses a simple register port with valid, write, address and data signals. Writes take effect at the clock edge. Read data is returned combinationally from the address in the same cycle.

Software starts, stops and clears counting with a single command register. It assigns events to counters through packed select registers that hold four counters each. It loads a counter indirectly: a select code is written first, then the value. When a general counter wraps, a sticky overflow flag is set. Each flag can be routed to the level interrupt `irq` through a mask that software sets and clears through separate registers.

Top module: `mem_perf_monitor`

## Requirements
- R1: After reset, every counter, the latched high cycle word, all select bytes, the preload select, the interrupt mask and the overflow status are zero, counting is stopped and `irq` is low.
- R2: A write to 0xC00 with bit 0 set and bit 1 clear starts counting. A write with bit 1 set stops counting, and this applies even when bit 0 is also set. A write with neither bit set leaves the running state unchanged.
- R3: A write to 0xC00 with bit 2 set clears all sixteen general counters, the cycle counter and the latched high word to zero. Select bytes, mask and status are kept.
- R4: Counter n is configured by byte 8*(n%4) of the register at 0xC68+4*(n/4). Bit 7 of that byte is the enable and bits 5:0 are the event code. Bit 6 reads back as zero.
- R5: While counting runs, an enabled counter increments by one in each cycle in which `ev_pulse[code]` is high. A disabled counter holds its value, and so does any counter while counting is stopped. Counter n reads at 0xC78+4*n.
- R6: A general counter wraps from 0xFFFFFFFF to 0. In that cycle its status bit 8+n at 0xCC8 is set, and it stays set until cleared. Bits 7:0 and 31:24 of 0xCC8 read zero.
- R7: The cycle counter is 56 bits wide and increments on every running cycle. A read of 0xC14 returns bits 31:0 and latches bits 55:32 into the register read at 0xC10, bits 23:0.
- R8: When 0xC08 holds 19+n (0 ≤ n ≤ 15), a write to 0xC0C loads counter n with the written value. With any other value in 0xC08, a write to 0xC0C has no effect. 0xC08 reads back its low 8 bits.
- R9: A preload in the same cycle as an increment of that counter wins. The counter takes the preloaded value and no overflow flag is set.
- R10: Writing 1s to bits 23:8 of 0xCB8 sets mask bits, and writing 1s to bits 23:8 of 0xCBC clears them. The mask reads at 0xCC0 bits 23:8, and its other bits read zero.
- R11: Writing 1s to bits 23:8 of 0xCC4 clears the matching status bits. A wrap in the same cycle keeps its bit set.
- R12: A status bit is set whether or not it is masked. `irq` is high exactly when some status bit and its mask bit are both set.
- R13: Offsets not listed above, including 0xC00 and 0xC0C, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| ev_pulse | input | 64 | Single-cycle event strobes |
| irq | output | 1 | Level interrupt: masked overflow status |

## Verification
A wrong counter, select byte or status bit becomes visible at the next read of its offset. The reference model is compared on every read and on `irq` in every cycle. A bad overflow flag or mask therefore shows on `irq` in the cycle after the wrap or mask write. Errors in the running state, priorities and preload show up as counter values that are off at the next readback. Directed sequences place wraps, preload collisions and set-versus-clear collisions in exact cycles. A random phase then mixes all register accesses with random event patterns.

// File: rtl/mem_perf_monitor.sv
module mem_perf_monitor #(
  parameter int NCNT = 16,
  parameter int CW   = 32,
  parameter int CYW  = 56,
  parameter int NEV  = 64,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic [NEV-1:0]  ev_pulse,
  output logic            irq
);
  localparam int EW  = $clog2(NEV);
  localparam int HW  = CYW - CW;
  localparam int OVB = 8;
  localparam int PL_BASE = 19;
  localparam logic [AW-1:0] A_CTRL = AW'('hC00);
  localparam logic [AW-1:0] A_TSEL = AW'('hC08);
  localparam logic [AW-1:0] A_PRE  = AW'('hC0C);
  localparam logic [AW-1:0] A_CHI  = AW'('hC10);
  localparam logic [AW-1:0] A_CLO  = AW'('hC14);
  localparam logic [AW-1:0] A_SEL  = AW'('hC68);
  localparam logic [AW-1:0] A_CNT  = AW'('hC78);
  localparam logic [AW-1:0] A_IEN  = AW'('hCB8);
  localparam logic [AW-1:0] A_IDIS = AW'('hCBC);
  localparam logic [AW-1:0] A_IMSK = AW'('hCC0);
  localparam logic [AW-1:0] A_ICLR = AW'('hCC4);
  localparam logic [AW-1:0] A_IST  = AW'('hCC8);

  logic [CW-1:0]   cnt [NCNT];
  logic [EW-1:0]   code [NCNT];
  logic [NCNT-1:0] en_bit, wrap, st, st_en;
  logic [CYW-1:0]  cyc;
  logic [HW-1:0]   hi_q;
  logic [7:0]      tsel;
  logic            run;

  wire wr      = bus_valid & bus_write;
  wire rd      = bus_valid & ~bus_write;
  wire wr_ctrl = wr && bus_addr == A_CTRL;
  wire clr_all = wr_ctrl && bus_wdata[2];
  wire [NCNT-1:0] clr_mask = (wr && bus_addr == A_ICLR) ? bus_wdata[OVB +: NCNT] : '0;

  assign irq = |(st & st_en);

  for (genvar g = 0; g < NCNT; g++) begin : g_ctr
    localparam int BO = 8 * (g % 4);
    wire sel_hit = wr && bus_addr == AW'(A_SEL + 4 * (g / 4));
    wire pl_hit  = wr && bus_addr == A_PRE && tsel == 8'(PL_BASE + g);
    wire inc     = run && en_bit[g] && ev_pulse[code[g]];
    assign wrap[g] = inc && (&cnt[g]) && !clr_all && !pl_hit;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[g] <= '0;
        en_bit[g] <= 1'b0;
        code[g] <= '0;
      end else begin
        if (clr_all)     cnt[g] <= '0;
        else if (pl_hit) cnt[g] <= bus_wdata;
        else if (inc)    cnt[g] <= cnt[g] + 1'b1;
        if (sel_hit) begin
          en_bit[g] <= bus_wdata[BO + 7];
          code[g]   <= bus_wdata[BO +: EW];
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0;
      cyc <= '0;
      hi_q <= '0;
      tsel <= '0;
      st <= '0;
      st_en <= '0;
    end else begin
      if (wr_ctrl) begin
        if (bus_wdata[1])      run <= 1'b0;
        else if (bus_wdata[0]) run <= 1'b1;
      end
      if (clr_all)  cyc <= '0;
      else if (run) cyc <= cyc + 1'b1;
      if (clr_all)                       hi_q <= '0;
      else if (rd && bus_addr == A_CLO)  hi_q <= cyc[CYW-1:CW];
      if (wr && bus_addr == A_TSEL) tsel <= bus_wdata[7:0];
      st <= (st & ~clr_mask) | wrap;
      if (wr && bus_addr == A_IEN)       st_en <= st_en | bus_wdata[OVB +: NCNT];
      else if (wr && bus_addr == A_IDIS) st_en <= st_en & ~bus_wdata[OVB +: NCNT];
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_TSEL) bus_rdata[7:0] = tsel;
    if (bus_addr == A_CHI)  bus_rdata[HW-1:0] = hi_q;
    if (bus_addr == A_CLO)  bus_rdata = cyc[CW-1:0];
    if (bus_addr == A_IMSK) bus_rdata[OVB +: NCNT] = st_en;
    if (bus_addr == A_IST)  bus_rdata[OVB +: NCNT] = st;
    for (int n = 0; n < NCNT; n++) begin
      if (bus_addr == AW'(A_SEL + 4 * (n / 4))) begin
        bus_rdata[8 * (n % 4) + 7]    = en_bit[n];
        bus_rdata[8 * (n % 4) +: EW]  = code[n];
      end
      if (bus_addr == AW'(A_CNT + 4 * n)) bus_rdata = cnt[n];
    end
  end
endmodule

// File: rtl/mem_perf_monitor_chk.sv
module mem_perf_monitor_chk #(
  parameter int NCNT = 16,
  parameter int CW   = 32,
  parameter int CYW  = 56,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic [CW-1:0]   bus_wdata,
  input logic [CW-1:0]   cnt0,
  input logic [CYW-1:0]  cyc,
  input logic            run,
  input logic [NCNT-1:0] st,
  input logic [NCNT-1:0] st_en
);
  localparam logic [AW-1:0] C_CTRL = AW'('hC00);
  localparam logic [AW-1:0] C_PRE  = AW'('hC0C);
  localparam logic [AW-1:0] C_IEN  = AW'('hCB8);
  localparam logic [AW-1:0] C_ICLR = AW'('hCC4);

  wire w = bus_valid && bus_write;

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w && bus_addr == C_CTRL && bus_wdata[1:0] == 2'b01 |=> run);

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w && bus_addr == C_CTRL && bus_wdata[1] |=> !run);

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w && bus_addr == C_CTRL && bus_wdata[2] |=> cnt0 == '0 && cyc == '0);

  // R5
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !(w && (bus_addr == C_CTRL || bus_addr == C_PRE)) |=> $stable(cnt0));

  // R7
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !(w && bus_addr == C_CTRL && bus_wdata[2]) |=> cyc == $past(cyc) + 1'b1);

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(w && bus_addr == C_ICLR) |=> ($past(st) & ~st) == '0);

  // R10
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w && bus_addr == C_IEN |=> (st_en & $past(bus_wdata[8 +: NCNT])) == $past(bus_wdata[8 +: NCNT]));
endmodule

bind mem_perf_monitor mem_perf_monitor_chk #(.NCNT(NCNT), .CW(CW), .CYW(CYW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt0(cnt[0]), .cyc(cyc),
  .run(run), .st(st), .st_en(st_en));

// File: tb/sim_mem_perf_monitor.sv
module sim_mem_perf_monitor;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [63:0] ev_pulse = '0;
  logic        irq;

  mem_perf_monitor u0 (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse), .irq(irq));

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string phase = "R1";

  logic [31:0] m_cnt [16];
  logic [7:0]  m_sel [16];
  logic [55:0] m_cyc;
  logic [23:0] m_hi;
  logic [7:0]  m_tsel;
  logic [15:0] m_en, m_st;
  bit          m_run;

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    logic [31:0] r = 0;
    if (a == 12'hC08) r = {24'h0, m_tsel};
    if (a == 12'hC10) r = {8'h0, m_hi};
    if (a == 12'hC14) r = m_cyc[31:0];
    if (a == 12'hCC0) r = {8'h0, m_en, 8'h0};
    if (a == 12'hCC8) r = {8'h0, m_st, 8'h0};
    for (int k = 0; k < 4; k++)
      if (a == 12'hC68 + 12'(4 * k)) r = {m_sel[4*k+3], m_sel[4*k+2], m_sel[4*k+1], m_sel[4*k]};
    for (int n = 0; n < 16; n++)
      if (a == 12'hC78 + 12'(4 * n)) r = m_cnt[n];
    return r;
  endfunction

  task automatic model_step(bit v, bit w, logic [11:0] a, logic [31:0] d, logic [63:0] ev);
    bit wr = v && w, rst_all = wr && a == 12'hC00 && d[2];
    logic [15:0] set = 0, clr = (wr && a == 12'hCC4) ? d[23:8] : 16'h0;
    for (int n = 0; n < 16; n++) begin
      bit inc = m_run && m_sel[n][7] && ev[m_sel[n][5:0]];
      bit pl = wr && a == 12'hC0C && m_tsel == 8'(19 + n);
      if (rst_all) m_cnt[n] = 0;
      else if (pl) m_cnt[n] = d;
      else if (inc) begin
        if (m_cnt[n] == 32'hFFFF_FFFF) set[n] = 1;
        m_cnt[n] = m_cnt[n] + 1;
      end
    end
    m_st = (m_st & ~clr) | set;
    if (rst_all) m_hi = 0;
    else if (v && !w && a == 12'hC14) m_hi = m_cyc[55:32];
    if (rst_all) m_cyc = 0;
    else if (m_run) m_cyc = m_cyc + 1;
    if (wr && a == 12'hC00) begin
      if (d[1]) m_run = 0;
      else if (d[0]) m_run = 1;
    end
    if (wr && a == 12'hC08) m_tsel = d[7:0];
    if (wr && a == 12'hCB8) m_en = m_en | d[23:8];
    if (wr && a == 12'hCBC) m_en = m_en & ~d[23:8];
    for (int n = 0; n < 16; n++)
      if (wr && a == 12'hC68 + 12'(4 * (n / 4))) m_sel[n] = d[8*(n%4) +: 8] & 8'hBF;
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [11:0] a, logic [31:0] d, logic [63:0] ev);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; ev_pulse = ev;
    #1;
    if (v && !w) check(bus_rdata, exp_rd(a), $sformatf("read %h", a));
    check({31'h0, irq}, {31'h0, |(m_st & m_en)}, "irq (R12)");
    @(posedge clk);
    model_step(v, w, a, d, ev);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d); step(1, 1, a, d, 0); endtask
  task automatic rd(logic [11:0] a); step(1, 0, a, 0, 0); endtask
  task automatic idle(logic [63:0] ev, int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0, ev); endtask
  task automatic rd_all();
    rd(12'hC08); rd(12'hC10); rd(12'hC14); rd(12'hCC0); rd(12'hCC8);
    for (int k = 0; k < 4; k++) rd(12'hC68 + 12'(4 * k));
    for (int n = 0; n < 16; n++) rd(12'hC78 + 12'(4 * n));
  endtask

  initial begin
    for (int n = 0; n < 16; n++) begin m_cnt[n] = 0; m_sel[n] = 0; end
    m_cyc = 0; m_hi = 0; m_tsel = 0; m_en = 0; m_st = 0; m_run = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    phase = "R1"; rd_all();
    phase = "R13";
    rd(12'hC00); rd(12'hC04); rd(12'hC0C); rd(12'hCD0); rd(12'h000); rd(12'hC64);
    phase = "R4";
    wr(12'hC68, 32'hC341FF80);
    wr(12'hC6C, 32'h87868584);
    wr(12'hC70, 32'h0000008A);
    wr(12'hC74, 32'h80000000);
    for (int k = 0; k < 4; k++) rd(12'hC68 + 12'(4 * k));
    phase = "R5";
    idle(64'hFFFF_FFFF_FFFF_FFFF, 3);
    rd_all();
    phase = "R2";
    wr(12'hC00, 1);
    phase = "R5";
    for (int i = 0; i < 20; i++) idle({32'(i * 37), 32'(i * 91 + 5)} ^ (64'h1 << i), 1);
    idle(64'h8000_0000_0000_00FF, 4);
    rd_all();
    phase = "R2";
    wr(12'hC00, 2); idle(64'hFFFF_FFFF_FFFF_FFFF, 5); rd_all();
    wr(12'hC00, 3); idle(64'hFFFF_FFFF_FFFF_FFFF, 3); rd(12'hC78); rd(12'hC14);
    wr(12'hC00, 0); idle(64'hFF, 2); rd(12'hC78);
    wr(12'hC00, 1); idle(64'hFF, 3); rd(12'hC78); rd(12'hC14);
    phase = "R7";
    rd(12'hC14); rd(12'hC10); idle(0, 4); rd(12'hC10); rd(12'hC14);
    phase = "R8";
    wr(12'hC08, 19 + 5); wr(12'hC0C, 32'hFFFF_FFFD); wr(12'hC08, 0); rd(12'hC08); rd(12'hC8C);
    wr(12'hC08, 18); wr(12'hC0C, 32'h1234_5678); wr(12'hC08, 35); wr(12'hC0C, 32'h1234_5678);
    rd(12'hC08); rd_all();
    wr(12'hC08, 19 + 15); wr(12'hC0C, 32'hABCD_0001); rd(12'hCB4);
    phase = "R6";
    wr(12'hC08, 0);
    idle(64'h20, 4); rd(12'hC8C); rd(12'hCC8);
    phase = "R12";
    check({31'h0, irq}, 0, "irq masked R12");
    phase = "R10";
    wr(12'hCB8, 32'hFFFF_FFFF); rd(12'hCC0);
    phase = "R12";
    idle(0, 1);
    wr(12'hCBC, 32'h0000_2000); rd(12'hCC0); idle(0, 1);
    phase = "R10";
    wr(12'hCBC, 32'h0000_FF00); rd(12'hCC0); wr(12'hCB8, 32'h0000_2000); rd(12'hCC0);
    phase = "R11";
    wr(12'hCC4, 32'h0000_2000); rd(12'hCC8); idle(0, 1);
    wr(12'hC08, 19); wr(12'hC0C, 32'hFFFF_FFFF); wr(12'hC08, 0);
    step(1, 1, 12'hCC4, 32'h0000_0100, 64'h1); rd(12'hCC8); rd(12'hC78);
    wr(12'hCC4, 32'h00FF_FFFF); rd(12'hCC8);
    phase = "R9";
    wr(12'hC08, 19); step(1, 1, 12'hC0C, 32'hFFFF_FFFF, 64'h1); rd(12'hC78);
    wr(12'hC08, 20); step(1, 1, 12'hC0C, 32'h0000_0010, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'hC7C);
    wr(12'hC08, 19); step(1, 1, 12'hC0C, 32'h0000_0007, 64'h1); rd(12'hCC8); rd(12'hC78);
    wr(12'hC08, 0);
    phase = "R3";
    idle(64'hFF, 3); wr(12'hC00, 32'h5); rd_all(); idle(64'hFF, 2); rd(12'hC78); rd(12'hC14);
    phase = "R5";
    for (int i = 0; i < 600; i++) begin
      logic [11:0] addrs [14] = '{12'hC00, 12'hC08, 12'hC0C, 12'hC10, 12'hC14, 12'hC68, 12'hC6C,
                                  12'hC70, 12'hC74, 12'hCB8, 12'hCBC, 12'hCC4, 12'hCC8, 12'hCC0};
      int r = $urandom_range(0, 19);
      logic [11:0] a = (r < 14) ? addrs[r] : 12'hC78 + 12'(4 * (r - 14));
      logic [31:0] d = {$urandom};
      logic [63:0] ev = {$urandom, $urandom};
      if (a == 12'hC00) d = {29'h0, ($urandom_range(0, 7) == 0), d[1:0]};
      if (a == 12'hC08) d = 32'($urandom_range(17, 36));
      if (a == 12'hC0C) d = 32'hFFFF_FFF0 | d[3:0];
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d, ev);
    end
    rd_all();
    done = 1;
    bus_valid = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule